// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block runs an external 8-bit successive-approximation converter that sits behind an 8-input analog multiplexer. It handles every control pin of the converter. It puts a channel number on three select lines and latches that number into the multiplexer with an address-latch pulse. It then sends a start pulse. The rising edge of that pulse clears the converter and the falling edge starts the conversion. The block waits for the end-of-conversion line to fall and then rise again. It opens the converter's tri-state output and captures the result together with the channel it came from.

The block also supplies the converter's clock. This clock is a square wave divided down from the system clock. While `run_i` is high the block converts continuously and steps through the active channels in round-robin order. A conversion takes between 64 and 72 converter clocks. If no result arrives within a configurable number of converter clocks, a watchdog abandons that conversion, flags it, and moves on to the next channel. The address-latch and start pulses can be sent one after the other with a gap between them, or merged into a single shared pulse for slow converter clocks.

Top module: `adcmux_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ale_o`, `start_o`, `oe_o`, `smp_valid_o`, `timeout_o` and `cvt_clk_o` are 0, and `sel_o` is 0.
- R2: `cvt_clk_o` is a square wave that is high for `CLK_DIV` system clock cycles and low for `CLK_DIV` system clock cycles.
- R3: `sel_o` carries the channel number in binary, with bit 2 as the most significant select line. It is held for `PULSE_W` cycles before `ale_o` rises and does not change while `ale_o` is high.
- R4: With `ALE_GAP` > 0, `ale_o` is high for `PULSE_W` cycles. Both lines are then low for `ALE_GAP` cycles, and `start_o` is then high for `PULSE_W` cycles.
- R5: With `ALE_GAP` = 0, `start_o` is identical to `ale_o` in every cycle.
- R6: `oe_o` rises three system clock cycles after `eoc_i` rises, once `eoc_i` has been seen low after the start pulse. It stays high for exactly two cycles, and the sample is taken from `data_i` at the end of that window.
- R7: Each completed conversion produces a one-cycle `smp_valid_o` pulse. The pulse carries the converted value on `smp_data_o` and the channel that was on `sel_o` during the latch pulse on `smp_chan_o`.
- R8: Successive conversions use channels 0, 1, …, `NUM_CH`-1 and then wrap back to 0.
- R9: When `NUM_CH` is 4 or less, `sel_o[2]` stays 0.
- R10: If `eoc_i` has not completed its low-then-high sequence within `TIMEOUT_CC` converter clock rising edges after the start pulse falls, `timeout_o` pulses for one cycle. No sample is produced for that conversion, and the next conversion uses the next channel.
- R11: When `run_i` goes low, the conversion already under way finishes and produces its sample. After that no further latch pulse is sent.
- R12: Conversions whose latency varies anywhere from 64 to 72 converter clocks complete without a timeout and return the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Continuous conversion enable |
| eoc_i | input | 1 | End-of-conversion from the converter (asynchronous) |
| data_i | input | 8 | Converter output bus, valid while `oe_o` is high |
| cvt_clk_o | output | 1 | Divided clock for the converter |
| sel_o | output | 3 | Multiplexer channel select, bit 2 most significant |
| ale_o | output | 1 | Address latch pulse |
| start_o | output | 1 | Start-of-conversion pulse |
| oe_o | output | 1 | Output enable for the converter's result latch |
| smp_data_o | output | 8 | Captured sample |
| smp_chan_o | output | 3 | Channel of the captured sample |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| timeout_o | output | 1 | One-cycle pulse when a conversion is abandoned |

## Verification
The bench drives two instances, each paired with a behavioural converter whose conversion time steps through every latency from 64 to 72 clocks. Each model returns a value that depends on both the conversion count and the channel, so a wrong capture time or a wrong channel tag shows up as a data mismatch. One instance uses separate latch and start pulses across four channels, and the other uses a merged pulse across eight. Together they separate the two pulse orderings and a power-of-two wrap from a three-bit wrap. A stalled conversion checks the watchdog's window and the channel skip that follows it. Dropping `run_i` in the middle of a stream checks that the conversion under way still completes.

// File: rtl/adcmux_pkg.sv
package adcmux_pkg;
  localparam int SEL_W = 3;
  localparam int SMP_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_ALE,
    S_GAP,
    S_START,
    S_WLOW,
    S_WHIGH,
    S_OE,
    S_CAPT
  } seq_state_t;
endpackage

// File: rtl/adcmux_clkdiv.sv
module adcmux_clkdiv #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic cvt_clk_o,
  output logic cc_tick_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cvt_clk_o <= 1'b0;
    end else if (cnt == LAST) begin
      cnt       <= '0;
      cvt_clk_o <= ~cvt_clk_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // tick marks the system edge on which the converter clock rises
  assign cc_tick_o = (cnt == LAST) && !cvt_clk_o;

  // R2: every tick is followed by a high converter clock
  a_r2_tick_rise: assert property (@(posedge clk) disable iff (rst)
    cc_tick_o |=> cvt_clk_o);
endmodule

// File: rtl/adcmux_chansel.sv
module adcmux_chansel #(
  parameter int NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      adv_i,
  output logic [adcmux_pkg::SEL_W-1:0] chan_o
);
  import adcmux_pkg::*;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_CH - 1);

  generate
    if (NUM_CH > 1 && (NUM_CH & (NUM_CH - 1)) == 0) begin : g_pow2
      localparam int CW = $clog2(NUM_CH);
      logic [CW-1:0] idx;
      always_ff @(posedge clk) begin
        if (rst)        idx <= '0;
        else if (adv_i) idx <= idx + 1'b1;
      end
      assign chan_o = SEL_W'(idx);
    end else begin : g_cmp
      logic [SEL_W-1:0] idx;
      always_ff @(posedge clk) begin
        if (rst)        idx <= '0;
        else if (adv_i) idx <= (idx == LAST) ? '0 : idx + 1'b1;
      end
      assign chan_o = idx;
    end
  endgenerate

  // R8: channel stays among the active ones and only moves on an advance
  a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
    chan_o <= LAST);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(chan_o));
endmodule

// File: rtl/adcmux_seq.sv
module adcmux_seq #(
  parameter int PULSE_W    = 2,
  parameter int ALE_GAP    = 1,
  parameter int TIMEOUT_CC = 100
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run_i,
  input  logic                         cc_tick_i,
  input  logic                         eoc_i,
  input  logic [adcmux_pkg::SMP_W-1:0] data_i,
  input  logic [adcmux_pkg::SEL_W-1:0] chan_i,
  output logic                         adv_o,
  output logic                         ale_o,
  output logic                         start_o,
  output logic                         oe_o,
  output logic [adcmux_pkg::SMP_W-1:0] smp_data_o,
  output logic [adcmux_pkg::SEL_W-1:0] smp_chan_o,
  output logic                         smp_valid_o,
  output logic                         timeout_o
);
  import adcmux_pkg::*;

  localparam int MAXP  = (PULSE_W > ALE_GAP) ? PULSE_W : ALE_GAP;
  localparam int CNT_W = $clog2(MAXP + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CC + 1);
  localparam logic [CNT_W-1:0] PW_LAST  = CNT_W'(PULSE_W - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'((ALE_GAP > 0) ? ALE_GAP - 1 : 0);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CC - 1);
  localparam bit MERGED = (ALE_GAP == 0);

  seq_state_t st, st_n;
  logic [CNT_W-1:0] cnt;
  logic [TO_W-1:0]  to_cnt;
  logic             cnt_clr, abort, waiting, to_hit;
  logic             eoc_s1, eoc_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_s1 <= 1'b0;
      eoc_s  <= 1'b0;
    end else begin
      eoc_s1 <= eoc_i;
      eoc_s  <= eoc_s1;
    end
  end

  assign waiting = (st == S_WLOW) || (st == S_WHIGH);
  assign to_hit  = waiting && cc_tick_i && (to_cnt == TO_LAST);

  always_comb begin
    st_n    = st;
    cnt_clr = 1'b0;
    abort   = 1'b0;
    unique case (st)
      S_IDLE:  if (run_i) begin st_n = S_SETUP; cnt_clr = 1'b1; end
      S_SETUP: if (cnt == PW_LAST) begin st_n = S_ALE; cnt_clr = 1'b1; end
      S_ALE:   if (cnt == PW_LAST) begin
                 st_n = MERGED ? S_WLOW : S_GAP; cnt_clr = 1'b1;
               end
      S_GAP:   if (cnt == GAP_LAST) begin st_n = S_START; cnt_clr = 1'b1; end
      S_START: if (cnt == PW_LAST) begin st_n = S_WLOW; cnt_clr = 1'b1; end
      S_WLOW:  if (to_hit) abort = 1'b1;
               else if (!eoc_s) st_n = S_WHIGH;
      S_WHIGH: if (to_hit) abort = 1'b1;
               else if (eoc_s) st_n = S_OE;
      S_OE:    st_n = S_CAPT;
      S_CAPT:  begin st_n = run_i ? S_SETUP : S_IDLE; cnt_clr = 1'b1; end
      default: st_n = S_IDLE;
    endcase
    if (abort) begin
      st_n    = run_i ? S_SETUP : S_IDLE;
      cnt_clr = 1'b1;
    end
  end

  assign adv_o = (st == S_CAPT) || abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      to_cnt      <= '0;
      ale_o       <= 1'b0;
      start_o     <= 1'b0;
      oe_o        <= 1'b0;
      smp_data_o  <= '0;
      smp_chan_o  <= '0;
      smp_valid_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_clr ? '0 : cnt + 1'b1;
      if (!waiting)       to_cnt <= '0;
      else if (cc_tick_i) to_cnt <= to_cnt + 1'b1;
      ale_o   <= (st_n == S_ALE);
      start_o <= (st_n == S_START) || (MERGED && st_n == S_ALE);
      oe_o    <= (st_n == S_OE) || (st_n == S_CAPT);
      smp_valid_o <= (st == S_CAPT);
      timeout_o   <= abort;
      if (st == S_CAPT) begin
        smp_data_o <= data_i;
        smp_chan_o <= chan_i;
      end
    end
  end

  // R6: a sample is only presented after the output enable window
  a_r6_valid_after_oe: assert property (@(posedge clk) disable iff (rst)
    smp_valid_o |-> $past(oe_o));
  // R10: an abandoned conversion never also yields a sample
  a_r10_no_dual: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid_o && timeout_o));
  // R6: output enable never overlaps the start pulse
  a_r6_oe_no_start: assert property (@(posedge clk) disable iff (rst)
    !(oe_o && start_o));

  generate
    if (MERGED) begin : g_chk_merged
      // R5: shared pulse
      a_r5_merged: assert property (@(posedge clk) disable iff (rst)
        ale_o == start_o);
    end else begin : g_chk_split
      // R4: start only rises after the latch pulse is gone
      a_r4_start_after_ale: assert property (@(posedge clk) disable iff (rst)
        $rose(start_o) |-> !$past(ale_o));
    end
  endgenerate
endmodule

// File: rtl/adcmux_ctrl.sv
module adcmux_ctrl #(
  parameter int CLK_DIV    = 4,
  parameter int NUM_CH     = 8,
  parameter int PULSE_W    = 2,
  parameter int ALE_GAP    = 1,
  parameter int TIMEOUT_CC = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       eoc_i,
  input  logic [7:0] data_i,
  output logic       cvt_clk_o,
  output logic [2:0] sel_o,
  output logic       ale_o,
  output logic       start_o,
  output logic       oe_o,
  output logic [7:0] smp_data_o,
  output logic [2:0] smp_chan_o,
  output logic       smp_valid_o,
  output logic       timeout_o
);
  logic cc_tick, adv;
  logic [2:0] chan;

  adcmux_clkdiv #(.CLK_DIV(CLK_DIV)) u_clkdiv (
    .clk       (clk),
    .rst       (rst),
    .cvt_clk_o (cvt_clk_o),
    .cc_tick_o (cc_tick)
  );

  adcmux_chansel #(.NUM_CH(NUM_CH)) u_chansel (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (adv),
    .chan_o (chan)
  );

  adcmux_seq #(
    .PULSE_W    (PULSE_W),
    .ALE_GAP    (ALE_GAP),
    .TIMEOUT_CC (TIMEOUT_CC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .cc_tick_i   (cc_tick),
    .eoc_i       (eoc_i),
    .data_i      (data_i),
    .chan_i      (chan),
    .adv_o       (adv),
    .ale_o       (ale_o),
    .start_o     (start_o),
    .oe_o        (oe_o),
    .smp_data_o  (smp_data_o),
    .smp_chan_o  (smp_chan_o),
    .smp_valid_o (smp_valid_o),
    .timeout_o   (timeout_o)
  );

  assign sel_o = chan;

  // R3: select lines hold while the multiplexer latches them
  a_r3_sel_stable: assert property (@(posedge clk) disable iff (rst)
    ale_o |-> $stable(sel_o));

  generate
    if (NUM_CH <= 4) begin : g_chk_small
      // R9: reduced configuration keeps the top select line low
      a_r9_msb_zero: assert property (@(posedge clk) disable iff (rst)
        sel_o[2] == 1'b0);
    end
  endgenerate
endmodule

// File: tb/test_adcmux_ctrl.sv
module adc_conv_model (
  input  logic        clk,
  input  logic        rst,
  input  logic        cvt_clk,
  input  logic [2:0]  sel,
  input  logic        ale,
  input  logic        start,
  input  logic        oe,
  input  logic        hang,
  output logic        eoc,
  output logic [7:0]  data,
  output logic        push,
  output logic [10:0] word
);
  logic cvt_q, start_q, busy, hung;
  logic [2:0] ch;
  logic [7:0] res;
  int ncc, nconv;

  function automatic logic [7:0] conv_val(input int n, input logic [2:0] c);
    return 8'((n * 37) + (int'(c) * 5) + 3);
  endfunction

  assign data = oe ? res : 8'h00;

  always @(posedge clk) begin
    push    <= 1'b0;
    cvt_q   <= cvt_clk;
    start_q <= start;
    if (rst) begin
      eoc <= 1'b1; busy <= 1'b0; hung <= 1'b0; ch <= '0; res <= '0;
      ncc <= 0; nconv <= 0; word <= '0;
    end else begin
      if (ale) ch <= sel;
      if (start && !start_q) begin
        eoc <= 1'b1; busy <= 1'b0;
      end else if (!start && start_q) begin
        eoc <= 1'b0; busy <= 1'b1; hung <= hang; ncc <= 0;
      end else if (busy && !hung && cvt_clk && !cvt_q) begin
        // latency 64..72 converter clocks, stepping through all values
        if (ncc == 63 + (nconv % 9)) begin
          busy  <= 1'b0;
          eoc   <= 1'b1;
          res   <= conv_val(nconv, ch);
          word  <= {ch, conv_val(nconv, ch)};
          push  <= 1'b1;
          nconv <= nconv + 1;
        end else begin
          ncc <= ncc + 1;
        end
      end
    end
  end
endmodule

module test_adcmux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run1 = 1'b0, run2 = 1'b0, hang1 = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic eoc1, cvt1, ale1, start1, oe1, v1, tmo1, push1;
  logic [7:0] din1, sd1;
  logic [2:0] sel1, sc1;
  logic [10:0] w1;
  logic eoc2, cvt2, ale2, start2, oe2, v2, tmo2, push2;
  logic [7:0] din2, sd2;
  logic [2:0] sel2, sc2;
  logic [10:0] w2;

  adcmux_ctrl #(.CLK_DIV(DIV), .NUM_CH(4), .PULSE_W(3), .ALE_GAP(2), .TIMEOUT_CC(100)) i_adcmux_ctrl (
    .clk(clk), .rst(rst), .run_i(run1), .eoc_i(eoc1), .data_i(din1),
    .cvt_clk_o(cvt1), .sel_o(sel1), .ale_o(ale1), .start_o(start1), .oe_o(oe1),
    .smp_data_o(sd1), .smp_chan_o(sc1), .smp_valid_o(v1), .timeout_o(tmo1));

  adc_conv_model u_model1 (
    .clk(clk), .rst(rst), .cvt_clk(cvt1), .sel(sel1), .ale(ale1), .start(start1),
    .oe(oe1), .hang(hang1), .eoc(eoc1), .data(din1), .push(push1), .word(w1));

  adcmux_ctrl #(.CLK_DIV(DIV), .NUM_CH(8), .PULSE_W(2), .ALE_GAP(0), .TIMEOUT_CC(100)) i_adcmux_ctrl_merged (
    .clk(clk), .rst(rst), .run_i(run2), .eoc_i(eoc2), .data_i(din2),
    .cvt_clk_o(cvt2), .sel_o(sel2), .ale_o(ale2), .start_o(start2), .oe_o(oe2),
    .smp_data_o(sd2), .smp_chan_o(sc2), .smp_valid_o(v2), .timeout_o(tmo2));

  adc_conv_model u_model2 (
    .clk(clk), .rst(rst), .cvt_clk(cvt2), .sel(sel2), .ale(ale2), .start(start2),
    .oe(oe2), .hang(1'b0), .eoc(eoc2), .data(din2), .push(push2), .word(w2));

  int n_chk = 0, n_fail = 0;
  int nsmp1 = 0, nsmp2 = 0, ntmo1 = 0, pred1 = 0, pred2 = 0;
  int sel_err = 0, msb_err = 0, merge_err = 0, ale_rises1 = 0;
  logic [2:0] sel1_prev = '0;
  logic ale1_prev = 1'b0;
  logic [10:0] q1[$];
  logic [10:0] q2[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: models push expected items, monitors pop on each sample
  always @(negedge clk) begin
    if (!rst) begin
      if (push1) q1.push_back(w1);
      if (push2) q2.push_back(w2);
      if (ale1 && sel1 != sel1_prev) sel_err++;           // R3
      if (sel1[2]) msb_err++;                             // R9
      if (ale2 != start2) merge_err++;                    // R5
      if (ale1 && !ale1_prev) ale_rises1++;
      if (v1) begin
        if (q1.size() == 0) chk(0, "R7 dut1 unexpected sample", 0, 1);
        else begin
          logic [10:0] w;
          w = q1.pop_front();
          chk({sc1, sd1} === w, "R7/R12 dut1 sample", int'({sc1, sd1}), int'(w));
        end
        chk(int'(sc1) == pred1, "R8 dut1 channel order", int'(sc1), pred1);
        pred1 = (pred1 + 1) % 4;
        nsmp1++;
      end
      if (tmo1) begin
        ntmo1++;
        pred1 = (pred1 + 1) % 4;                          // R10 channel skip
      end
      if (v2) begin
        if (q2.size() == 0) chk(0, "R5 dut2 unexpected sample", 0, 1);
        else begin
          logic [10:0] w;
          w = q2.pop_front();
          chk({sc2, sd2} === w, "R5/R7 dut2 sample", int'({sc2, sd2}), int'(w));
        end
        chk(int'(sc2) == pred2, "R8 dut2 channel order", int'(sc2), pred2);
        pred2 = (pred2 + 1) % 8;
        nsmp2++;
      end
      chk(!tmo2, "R12 dut2 no timeout", int'(tmo2), 0);
      sel1_prev = sel1;
      ale1_prev = ale1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w, t, n0, r0, base;
    repeat (5) @(negedge clk);
    // R1: reset state, during and just after reset
    chk({ale1, start1, oe1, v1, tmo1, cvt1} == 6'b0, "R1 outputs in reset", int'({ale1, start1, oe1, v1, tmo1, cvt1}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({ale1, start1, oe1, v1, tmo1} == 5'b0 && sel1 == 3'd0, "R1 outputs after reset",
        int'({ale1, start1, oe1, v1, tmo1, sel1}), 0);

    // R2: converter clock high width
    while (!cvt1) @(negedge clk);
    w = 0;
    while (cvt1) begin w++; @(negedge clk); end
    chk(w == DIV, "R2 cvt clock high width", w, DIV);
    w = 0;
    while (!cvt1) begin w++; @(negedge clk); end
    chk(w == DIV, "R2 cvt clock low width", w, DIV);

    run1 = 1'b1;
    run2 = 1'b1;
    // R4: latch width, gap, start width
    while (!ale1) @(negedge clk);
    w = 0;
    while (ale1) begin w++; @(negedge clk); end
    chk(w == 3, "R4 ale width", w, 3);
    w = 0;
    while (!start1) begin w++; @(negedge clk); end
    chk(w == 2, "R4 ale to start gap", w, 2);
    w = 0;
    while (start1) begin w++; @(negedge clk); end
    chk(w == 3, "R4 start width", w, 3);
    // R6: output enable delay and width
    while (eoc1) @(negedge clk);
    while (!eoc1) @(negedge clk);
    w = 0;
    while (!oe1) begin w++; @(negedge clk); end
    chk(w == 3, "R6 eoc to oe delay", w, 3);
    w = 0;
    while (oe1) begin w++; @(negedge clk); end
    chk(w == 2, "R6 oe width", w, 2);

    while (nsmp1 < 6) @(negedge clk);

    // R10: stalled conversion
    while (!start1) @(negedge clk);
    hang1 = 1'b1;
    #1 base = nsmp1;
    t = 0;
    while (!tmo1 && t < 2000) begin t++; @(negedge clk); end
    hang1 = 1'b0;
    chk(t >= 390 && t <= 415, "R10 timeout window", t, 400);
    #1;
    chk(nsmp1 == base, "R10 no sample for aborted conversion", nsmp1, base);
    chk(ntmo1 == 1, "R10 one timeout pulse", ntmo1, 1);
    while (nsmp1 < base + 3) @(negedge clk);

    // R11: stop mid stream
    do @(negedge clk); while (!v1);
    run1 = 1'b0;
    run2 = 1'b0;
    #1 n0 = nsmp1;
    r0 = ale_rises1;
    repeat (1000) @(negedge clk);
    chk(nsmp1 == n0 + 1, "R11 in-flight conversion completes", nsmp1, n0 + 1);
    chk(ale_rises1 == r0 + 1, "R11 no latch pulse after stop", ale_rises1, r0 + 1);
    chk(!oe1 && !ale1 && !start1, "R11 idle outputs", int'({oe1, ale1, start1}), 0);

    chk(sel_err == 0, "R3 select stable during latch", sel_err, 0);
    chk(msb_err == 0, "R9 top select line low", msb_err, 0);
    chk(merge_err == 0, "R5 merged pulse", merge_err, 0);
    chk(nsmp2 >= 9, "R8 dut2 wrapped past channel 7", nsmp2, 9);
    chk(nsmp1 >= 9, "R12 all latencies seen", nsmp1, 9);
    chk(q1.size() == 0 && q2.size() == 0, "R7 all conversions delivered",
        q1.size() + q2.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule